// File: doc/BRIEF.md
# SHA-256 Two-Round Packed Compression Core

This core runs the compression loop of SHA-256 over one 512-bit block. The message schedule and padding are handled upstream. Each cycle the feeder supplies two round sums, each the message word plus the round constant for that round. The core does not store or add round constants itself.

The eight working words live in two 128-bit registers. One holds {a,b,e,f} and the other holds {c,d,g,h}. Across two rounds the c, d, g and h words take the old a, b, e and f, so each step computes only the fresh {a,b,e,f} quadruple. It writes that quadruple over the register holding the stale half. The two registers swap roles on every step.

A block starts from either the standard initial hash value or a chaining value from a port. At the end each word of the final working state is added to the chaining value, and the 256-bit result is presented with a one-cycle done strobe.

Top module: `sha2p_core`

## Requirements
- R1: During and after reset, until the first start is accepted, `busy` and `done` are 0, `step_idx` is 0 and `digest` is all zeros.
- R2: A block started with `use_iv`=1 starts from the standard initial words a..h = 6a09e667, bb67ae85, 3c6ef372, a54ff53a, 510e527f, 9b05688c, 1f83d9ab, 5be0cd19 (hex). `chain_in` is ignored for that block.
- R3: A block started with `use_iv`=0 takes its initial words from `chain_in`, with a in bits [255:224] down to h in bits [31:0].
- R4: The core runs NUM_ROUNDS standard SHA-256 rounds in NUM_ROUNDS/2 steps, one step per cycle. While a step runs, `step_idx` shows its number s, counting up from 0. `wk_pair[63:32]` is taken as the sum for round 2s and `wk_pair[31:0]` as the sum for round 2s+1.
- R5: `digest` is the word-wise sum modulo 2^32 of the chaining value and the final working state, laid out a..h from the most significant word down.
- R6: `done` is high for exactly one cycle. With the default of 64 rounds, that cycle follows the 33rd rising edge after the edge that accepted start. `digest` changes only at the edge that raises `done`.
- R7: Start asserted while the core is busy is ignored. It alters neither the result nor the timing of the block in progress.
- R8: `busy` rises only after an accepted start and is low in the cycle where `done` is high. A start in that same cycle is accepted.
- R9: `step_idx` is 0 whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a block; taken only when idle |
| use_iv | input | 1 | 1: start from the standard initial value; 0: use chain_in |
| chain_in | input | 256 | Chaining value, word a in the top bits |
| wk_pair | input | 64 | Two round sums for the current step, earlier round in the top half |
| busy | output | 1 | Block in progress (steps plus final addition) |
| step_idx | output | 5 | Current step number (width $clog2(NUM_ROUNDS/2)) |
| digest | output | 256 | Result of the last block, word a in the top bits |
| done | output | 1 | One-cycle strobe: digest just updated |

## Verification
Two things can happen in the same cycle. The `done` strobe of one block can meet the acceptance of the next start, and a stray start can arrive while a block is still stepping. The back-to-back case is driven by raising start in the very cycle where `done` is seen. That case passes only if the first digest matches the bench's single-round reference model and the second block then completes on the regular cycle count with its own correct digest. The stray case raises start mid-block with a flipped chaining value and source select. The block in progress must still report its original digest on the unchanged cycle.

// File: rtl/sha2p_pkg.sv
package sha2p_pkg;

   typedef logic [31:0] word_t;

   typedef struct packed {
      word_t a; word_t b; word_t c; word_t d;
      word_t e; word_t f; word_t g; word_t h;
   } st8_t;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RUN  = 2'd1,
      PH_FIN  = 2'd2
   } phase_e;

   localparam logic [255:0] INIT_HASH = {
      32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
      32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19 };

   function automatic word_t rotr(word_t x, int n);
      return (x >> n) | (x << (32 - n));
   endfunction

   function automatic word_t big_sig0(word_t x);
      return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
   endfunction

   function automatic word_t big_sig1(word_t x);
      return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
   endfunction

   // returns {new_a, new_e} of one round
   function automatic logic [63:0] round_ae(st8_t s, word_t wk);
      word_t t1, t2;
      t1 = s.h + big_sig1(s.e) + ((s.e & s.f) ^ (~s.e & s.g)) + wk;
      t2 = big_sig0(s.a) + ((s.a & s.b) ^ (s.a & s.c) ^ (s.b & s.c));
      return {t1 + t2, s.d + t1};
   endfunction

   function automatic st8_t round_full(st8_t s, word_t wk);
      logic [63:0] ae;
      st8_t n;
      ae  = round_ae(s, wk);
      n.a = ae[63:32]; n.b = s.a; n.c = s.b; n.d = s.c;
      n.e = ae[31:0];  n.f = s.e; n.g = s.f; n.h = s.g;
      return n;
   endfunction

endpackage

// File: rtl/sha2p_round2.sv
module sha2p_round2
   import sha2p_pkg::*;
(
   input  logic [127:0] top_i,   // {a,b,e,f}
   input  logic [127:0] bot_i,   // {c,d,g,h}
   input  logic [63:0]  wk_i,    // earlier round in the upper half
   output logic [127:0] top_o    // {a,b,e,f} two rounds later
);

   st8_t        s0;
   st8_t        s1;
   logic [63:0] ae2;

   assign s0 = '{a: top_i[127:96], b: top_i[95:64],
                 c: bot_i[127:96], d: bot_i[95:64],
                 e: top_i[63:32],  f: top_i[31:0],
                 g: bot_i[63:32],  h: bot_i[31:0]};

   assign s1  = round_full(s0, wk_i[63:32]);
   assign ae2 = round_ae(s1, wk_i[31:0]);

   // second-round b and f are the first-round a and e
   assign top_o = {ae2[63:32], s1.a, ae2[31:0], s1.e};

endmodule

// File: rtl/sha2p_ctrl.sv
module sha2p_ctrl
   import sha2p_pkg::*;
#(
   parameter  int STEPS = 32,
   localparam int IDX_W = $clog2(STEPS)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic             load_o,
   output logic             step_o,
   output logic             fin_o,
   output logic             busy_o,
   output logic [IDX_W-1:0] idx_o
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(STEPS - 1);

   phase_e           ph;
   logic [IDX_W-1:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= PH_IDLE;
         idx <= '0;
      end else begin
         unique case (ph)
            PH_IDLE: if (start_i) ph <= PH_RUN;
            PH_RUN: begin
               if (idx == LAST) begin
                  idx <= '0;
                  ph  <= PH_FIN;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            PH_FIN:  ph <= PH_IDLE;
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign load_o = (ph == PH_IDLE) && start_i;
   assign step_o = (ph == PH_RUN);
   assign fin_o  = (ph == PH_FIN);
   assign busy_o = (ph != PH_IDLE);
   assign idx_o  = idx;

endmodule

// File: rtl/sha2p_fold.sv
module sha2p_fold #(
   parameter  int WORDS  = 8,
   parameter  int WORD_W = 32,
   localparam int TOT_W  = WORDS * WORD_W
)(
   input  logic [TOT_W-1:0] chain_i,
   input  logic [TOT_W-1:0] state_i,
   output logic [TOT_W-1:0] sum_o
);

   for (genvar w = 0; w < WORDS; w++) begin : g_add
      assign sum_o[w*WORD_W +: WORD_W] =
         chain_i[w*WORD_W +: WORD_W] + state_i[w*WORD_W +: WORD_W];
   end

endmodule

// File: rtl/sha2p_core.sv
module sha2p_core
   import sha2p_pkg::*;
#(
   parameter  int NUM_ROUNDS = 64,
   localparam int STEPS      = NUM_ROUNDS / 2,
   localparam int IDX_W      = $clog2(STEPS)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             use_iv,
   input  logic [255:0]     chain_in,
   input  logic [63:0]      wk_pair,
   output logic             busy,
   output logic [IDX_W-1:0] step_idx,
   output logic [255:0]     digest,
   output logic             done
);

   if (NUM_ROUNDS < 4 || (NUM_ROUNDS % 2) != 0) begin : g_bad_rounds
      $error("sha2p_core: NUM_ROUNDS must be even and at least 4");
   end

   logic         load, step, fin;
   logic [127:0] reg_a, reg_c;
   logic [127:0] cur_top, cur_bot, nxt_top;
   logic [127:0] end_top, end_bot;
   logic [255:0] chain_q, init_st, sum;

   sha2p_ctrl #(.STEPS(STEPS)) i_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .load_o  (load),
      .step_o  (step),
      .fin_o   (fin),
      .busy_o  (busy),
      .idx_o   (step_idx)
   );

   // the fresh half moves between the registers on every step
   assign cur_top = step_idx[0] ? reg_c : reg_a;
   assign cur_bot = step_idx[0] ? reg_a : reg_c;

   sha2p_round2 i_round2 (
      .top_i (cur_top),
      .bot_i (cur_bot),
      .wk_i  (wk_pair),
      .top_o (nxt_top)
   );

   if ((STEPS % 2) == 0) begin : g_even_steps
      assign end_top = reg_a;
      assign end_bot = reg_c;
   end else begin : g_odd_steps
      assign end_top = reg_c;
      assign end_bot = reg_a;
   end

   assign init_st = use_iv ? INIT_HASH : chain_in;

   sha2p_fold #(.WORDS(8), .WORD_W(32)) i_fold (
      .chain_i (chain_q),
      .state_i ({end_top[127:64], end_bot[127:64], end_top[63:0], end_bot[63:0]}),
      .sum_o   (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_a   <= '0;
         reg_c   <= '0;
         chain_q <= '0;
         digest  <= '0;
         done    <= 1'b0;
      end else begin
         done <= fin;
         if (load) begin
            chain_q <= init_st;
            reg_a   <= {init_st[255:192], init_st[127:64]};
            reg_c   <= {init_st[191:128], init_st[63:0]};
         end
         if (step) begin
            if (step_idx[0]) reg_a <= nxt_top;
            else             reg_c <= nxt_top;
         end
         if (fin) digest <= sum;
      end
   end

endmodule

// File: rtl/sha2p_core_chk.sv
module sha2p_core_chk #(
   parameter  int NUM_ROUNDS = 64,
   localparam int STEPS      = NUM_ROUNDS / 2,
   localparam int IDX_W      = $clog2(STEPS)
)(
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic [IDX_W-1:0] step_idx,
   input logic [255:0]     digest,
   input logic             done
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(STEPS - 1);

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_digest_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(digest));

   assert_idle_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_busy_needs_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   assert_step_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && $past(step_idx) != LAST)
         |-> step_idx == $past(step_idx) + 1'b1);

   assert_idle_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> step_idx == '0);

endmodule

bind sha2p_core sha2p_core_chk #(.NUM_ROUNDS(NUM_ROUNDS)) i_sha2p_core_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .step_idx (step_idx),
   .digest   (digest),
   .done     (done)
);

// File: tb/test_sha2p_core.sv
module test_sha2p_core;

   localparam int CLK_PERIOD = 10;
   localparam logic [255:0] STD_IV = {
      32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
      32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19 };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         use_iv = 1'b0;
   logic [255:0] chain_in = '0;
   logic [63:0]  wk_pair = '0;
   logic         busy;
   logic [4:0]   step_idx;
   logic [255:0] digest;
   logic         done;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0]  wk_arr [64];
   logic [255:0] exp_dig;

   always #(CLK_PERIOD/2) clk = ~clk;

   sha2p_core i_sha2p_core (
      .clk(clk), .rst_n(rst_n), .start(start), .use_iv(use_iv),
      .chain_in(chain_in), .wk_pair(wk_pair), .busy(busy),
      .step_idx(step_idx), .digest(digest), .done(done));

   function automatic logic [31:0] ror(logic [31:0] x, int n);
      return (x >> n) | (x << (32 - n));
   endfunction

   // plain one-round-at-a-time reference over eight separate words
   function automatic logic [255:0] ref_hash(logic [255:0] ch);
      logic [31:0] v [8];
      logic [31:0] t1, t2;
      logic [255:0] r;
      for (int j = 0; j < 8; j++) v[j] = ch[255 - 32*j -: 32];
      for (int i = 0; i < 64; i++) begin
         t1 = v[7] + (ror(v[4],6) ^ ror(v[4],11) ^ ror(v[4],25))
              + ((v[4] & v[5]) ^ (~v[4] & v[6])) + wk_arr[i];
         t2 = (ror(v[0],2) ^ ror(v[0],13) ^ ror(v[0],22))
              + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
         for (int j = 7; j > 0; j--) v[j] = v[j-1];
         v[4] = v[4] + t1;
         v[0] = t1 + t2;
      end
      for (int j = 0; j < 8; j++) r[255 - 32*j -: 32] = ch[255 - 32*j -: 32] + v[j];
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [255:0] act,
                      input logic [255:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // call at a negedge; arms a block for the next rising edge
   task automatic kick(input bit iv, input logic [255:0] ch, input int seed);
      for (int i = 0; i < 64; i++)
         wk_arr[i] = (seed < 0) ? 32'hffffffff
                   : (32'(seed) * 32'h9e3779b9) ^ ((32'(i) * 32'h85ebca6b) + 32'h0badf00d);
      exp_dig  = ref_hash(iv ? STD_IV : ch);
      use_iv   = iv;
      chain_in = ch;
      start    = 1'b1;
      wk_pair  = {wk_arr[0], wk_arr[1]};
   endtask

   // follows a kicked block to its done cycle; returns at that negedge
   task automatic follow(input string req, input int inj_at);
      bit seen = 0;
      for (int n = 1; n <= 40 && !seen; n++) begin
         @(negedge clk);
         if (n == inj_at) begin
            start = 1'b1; chain_in = ~chain_in; use_iv = ~use_iv;
         end else begin
            start = 1'b0;
         end
         wk_pair = {wk_arr[2*int'(step_idx)], wk_arr[2*int'(step_idx)+1]};
         if (n <= 32)
            chk(step_idx == 5'(n-1), "R4 step index", 256'(step_idx), 256'(n-1));
         if (n <= 33)
            chk(busy == 1'b1, "R8 busy during block", 256'(busy), 256'd1);
         if (done) begin
            seen = 1;
            chk(n == 34, "R6 done cycle", 256'(n), 256'd34);
            chk(busy == 1'b0, "R8 idle at done", 256'(busy), 256'd0);
            chk(digest == exp_dig, req, digest, exp_dig);
         end
      end
      if (!seen) chk(1'b0, "R6 done never seen", 256'd0, 256'd1);
   endtask

   task automatic after_done();
      logic [255:0] held = digest;
      @(negedge clk);
      chk(done == 1'b0, "R6 single pulse", 256'(done), 256'd0);
      chk(digest == held, "R6 digest held", digest, held);
      chk(busy == 1'b0 && step_idx == 5'd0, "R9 idle index", 256'(step_idx), 256'd0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R1 reset flags", 256'({busy, done}), 256'd0);
      chk(digest == '0, "R1 reset digest", digest, 256'd0);
      chk(step_idx == 5'd0, "R1 reset index", 256'(step_idx), 256'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0 && digest == '0, "R1 after reset",
          digest, 256'd0);
   endtask

   task automatic t_iv();
      @(negedge clk);
      kick(1'b1, {8{32'hdeadbeef}}, 1);   // chain_in must be ignored
      follow("R2 R5 initial value digest", 0);
      after_done();
   endtask

   task automatic t_chain();
      @(negedge clk);
      kick(1'b0, {32'h01234567, 32'h89abcdef, 32'hfedcba98, 32'h76543210,
                  32'h0f1e2d3c, 32'h4b5a6978, 32'h8796a5b4, 32'hc3d2e1f0}, 2);
      follow("R3 R4 chained digest", 0);
      after_done();
   endtask

   task automatic t_wrap();
      @(negedge clk);
      kick(1'b0, {8{32'hffffffff}}, -1);
      follow("R5 modular wrap digest", 0);
      after_done();
   endtask

   task automatic t_busy_start();
      @(negedge clk);
      kick(1'b0, {8{32'h13579bdf}}, 3);
      follow("R7 start while busy ignored", 10);
      after_done();
   endtask

   task automatic t_back_to_back();
      @(negedge clk);
      kick(1'b1, '0, 4);
      follow("R8 first of pair", 0);
      kick(1'b0, {8{32'h2468ace0}}, 5);   // same cycle as done
      follow("R8 back-to-back second", 0);
      after_done();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      t_reset();
      t_iv();
      t_chain();
      t_wrap();
      t_busy_start();
      t_back_to_back();
      finish_run();
   end

endmodule